// File: doc/BRIEF.md
# SPI-Mode Card Command Engine

This block is the host-side sequencer for a memory card that runs in SPI mode. On a start strobe it takes a 6-bit opcode, a 32-bit argument and a response type. It serialises the fixed command frame through its own byte shifter, then polls the card until a response token appears. It collects the response bytes and reports the outcome as a one-cycle done pulse, an error code and the captured response words. A separate wake request clocks the power-up idle pattern while chip select is held inactive.

Each transaction uses one serial clock divider, chosen from the opcode. The reset opcode (0) uses the slow divider, and every other opcode uses the fast one. Each bit lasts divider+1 reference cycles, and both divider values must be at least 1. The serial clock idles low. MOSI changes while SCLK is low, and MISO is sampled in the high half of each bit. All bytes move MSB first.

Top module: `spi_card_cmd`

## Requirements
- R1: A command sends exactly eight bytes before any response byte, in this order: 0xFF, then 0x40 OR opcode, then argument bits 31:24, 23:16, 15:8 and 7:0, then the check byte, then 0xFF. Every byte is shifted MSB first.
- R2: The check byte is 0x95 when the opcode is 0, 0x87 when the opcode is 8, and 0x00 for every other opcode.
- R3: After the frame, the engine clocks 0xFF bytes and accepts the first received byte whose bit 7 is 0. If TMO_LIMIT polled bytes all have bit 7 set, it ends with err = 1 (timeout), and both rsp_short and rsp_word read 0.
- R4: With rsp_kind = 1 (two-byte type), one further byte is read, and rsp_short = {second byte, first byte}.
- R5: With rsp_kind = 2 (five-byte type), four further bytes are read and packed into rsp_word with the earliest byte in bits 31:24. rsp_short = {8'h00, first byte}. With rsp_kind 0 or 3, no further byte is read.
- R6: If the accepted first byte is neither 0x00 nor 0x01, err = 2 (I/O error). The further bytes for the selected type are still read. err = 0 means success.
- R7: Opcode 0 runs at SLOW_DIV and every other opcode runs at FAST_DIV. One bit period is divider+1 reference cycles, and SCLK is low whenever no byte is moving.
- R8: A wake_req clocks WAKE_BYTES bytes of 0xFF at SLOW_DIV with cs_n held high, then pulses done with err = 0.
- R9: cs_n goes low before the first frame byte and stays low through the last response byte. It then goes high, and one more 0xFF byte is clocked before done.
- R10: done is high for exactly one cycle per transaction. err and the response outputs hold their values until the next accepted start.
- R11: start and wake_req are ignored while busy is high. The transaction in progress and its frame are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | 1 | Start the power-up idle pattern (takes priority over start) |
| start | input | 1 | Begin one command transaction |
| opcode | input | 6 | Command index |
| arg | input | 32 | Command argument |
| rsp_kind | input | 2 | 0: one byte, 1: two bytes, 2: one plus four bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 ok, 1 timeout, 2 I/O error |
| rsp_short | output | 16 | First response byte, with the second byte above it for type 1 |
| rsp_word | output | 32 | Four trailing bytes for type 2 |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the card |
| miso | input | 1 | Serial data from the card |
| cs_n | output | 1 | Card select, active low |

## Verification
Results are due only after the whole byte train has been shifted. done rises on the clock after the shifter finishes the trailing idle byte, and err, rsp_short and rsp_word are registered no later than that edge. The bench therefore waits for done at falling clock edges and reads every result in that same half-cycle. It then checks one falling edge later that done has dropped, and ten cycles later that err has not moved. The serial traffic is checked per byte by a card model that samples MOSI and cs_n on rising SCLK and updates MISO on falling SCLK. That is the same half-bit offset the shifter relies on, so the frame contents, the select window and the bit period can all be compared against the byte count that the response type implies.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_IO      = 2'd2
    } err_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAKE,
        S_FRAME,
        S_POLL,
        S_EXTRA,
        S_TAIL
    } seq_e;

    typedef struct packed {
        logic [5:0]  op;
        logic [31:0] arg;
        logic [1:0]  kind;
    } cmd_t;

    localparam logic [7:0] IDLE_BYTE  = 8'hFF;
    localparam logic [2:0] FRAME_LAST = 3'd7;

    function automatic logic [7:0] check_byte(input logic [5:0] op);
        if (op == 6'd0)      return 8'h95;
        else if (op == 6'd8) return 8'h87;
        else                 return 8'h00;
    endfunction

    function automatic logic token_good(input logic [7:0] b);
        return (b == 8'h00) || (b == 8'h01);
    endfunction

    function automatic logic [2:0] trailing_bytes(input logic [1:0] kind);
        case (kind)
            2'd1:    return 3'd1;
            2'd2:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/spicmd_shifter.sv
module spicmd_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [7:0]       tx_byte,
    input  logic [DIV_W-1:0] div,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             fin,
    output logic [7:0]       rx_byte,
    output logic             active
);
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sh_tx;
    logic [7:0]       sh_rx;
    logic [DIV_W:0]   half;

    always_comb begin
        half = ({1'b0, div} + 1'b1) >> 1;
    end

    assign sclk    = active && ({1'b0, cnt} >= half);
    assign mosi    = active ? sh_tx[7] : 1'b1;
    assign rx_byte = sh_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            bitn   <= '0;
            sh_tx  <= 8'hFF;
            sh_rx  <= 8'h00;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    cnt    <= '0;
                    bitn   <= '0;
                    sh_tx  <= tx_byte;
                end
            end else begin
                if ({1'b0, cnt} == half)
                    sh_rx <= {sh_rx[6:0], miso};
                if (cnt == div) begin
                    cnt <= '0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                    end else begin
                        bitn  <= bitn + 3'd1;
                        sh_tx <= {sh_tx[6:0], 1'b1};
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R1: data line does not move while the clock is high
    p_mosi_steady_r1: assert property (@(posedge clk) disable iff (rst)
        (active && sclk && $past(active && sclk)) |-> $stable(mosi));

    // R7: the completion flag follows the shifter going quiet
    p_fin_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        fin |-> !active);

    // R7: clock stays low while idle
    p_sclk_rest_r7: assert property (@(posedge clk) disable iff (rst)
        (!active && !$past(go)) |-> !sclk);

endmodule

// File: rtl/spicmd_frame_mux.sv
module spicmd_frame_mux
    import spicmd_pkg::*;
(
    input  logic [2:0]  idx,
    input  logic [5:0]  op,
    input  logic [31:0] arg,
    output logic [7:0]  frame_byte
);
    always_comb begin
        case (idx)
            3'd1:    frame_byte = {2'b01, op};
            3'd2:    frame_byte = arg[31:24];
            3'd3:    frame_byte = arg[23:16];
            3'd4:    frame_byte = arg[15:8];
            3'd5:    frame_byte = arg[7:0];
            3'd6:    frame_byte = check_byte(op);
            default: frame_byte = IDLE_BYTE;
        endcase
    end
endmodule

// File: rtl/spicmd_sequencer.sv
module spicmd_sequencer
    import spicmd_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int SLOW_DIV   = 144,
    parameter int FAST_DIV   = 48,
    parameter int TMO_LIMIT  = 1000,
    parameter int WAKE_BYTES = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wake_req,
    input  logic             start,
    input  cmd_t             cmd_in,
    input  logic             fin,
    input  logic [7:0]       rx_byte,
    input  logic [7:0]       frame_byte,
    output logic [2:0]       frame_idx,
    output cmd_t             cmd_q,
    output logic             go,
    output logic [7:0]       tx_byte,
    output logic [DIV_W-1:0] div,
    output logic             cs_n,
    output logic             busy,
    output logic             done,
    output logic [1:0]       err,
    output logic [15:0]      rsp_short,
    output logic [31:0]      rsp_word
);
    localparam int IDX_W = (WAKE_BYTES > 8) ? $clog2(WAKE_BYTES) : 3;
    localparam int PC_W  = (TMO_LIMIT > 1) ? $clog2(TMO_LIMIT) : 1;
    localparam logic [IDX_W-1:0] WAKE_LAST = IDX_W'(WAKE_BYTES - 1);
    localparam logic [PC_W-1:0]  POLL_LAST = PC_W'(TMO_LIMIT - 1);
    localparam logic [DIV_W-1:0] DIV_SLOW  = DIV_W'(SLOW_DIV);
    localparam logic [DIV_W-1:0] DIV_FAST  = DIV_W'(FAST_DIV);

    seq_e            st;
    logic [IDX_W-1:0] idx;
    logic [PC_W-1:0]  poll_cnt;
    logic [2:0]       extra_left;
    logic             launch;
    err_e             res_q;
    err_e             err_q;

    assign go        = launch;
    assign busy      = (st != S_IDLE);
    assign frame_idx = idx[2:0];
    assign tx_byte   = (st == S_FRAME) ? frame_byte : IDLE_BYTE;
    assign err       = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            idx        <= '0;
            poll_cnt   <= '0;
            extra_left <= '0;
            launch     <= 1'b0;
            res_q      <= ERR_NONE;
            err_q      <= ERR_NONE;
            cmd_q      <= '0;
            div        <= DIV_SLOW;
            cs_n       <= 1'b1;
            done       <= 1'b0;
            rsp_short  <= '0;
            rsp_word   <= '0;
        end else begin
            launch <= 1'b0;
            done   <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (wake_req) begin
                        st     <= S_WAKE;
                        idx    <= '0;
                        div    <= DIV_SLOW;
                        cs_n   <= 1'b1;
                        err_q  <= ERR_NONE;
                        launch <= 1'b1;
                    end else if (start) begin
                        st        <= S_FRAME;
                        idx       <= '0;
                        cmd_q     <= cmd_in;
                        div       <= (cmd_in.op == 6'd0) ? DIV_SLOW : DIV_FAST;
                        cs_n      <= 1'b0;
                        err_q     <= ERR_NONE;
                        res_q     <= ERR_NONE;
                        rsp_short <= '0;
                        rsp_word  <= '0;
                        launch    <= 1'b1;
                    end
                end
                S_WAKE: if (fin) begin
                    if (idx == WAKE_LAST) begin
                        st    <= S_IDLE;
                        done  <= 1'b1;
                        err_q <= ERR_NONE;
                    end else begin
                        idx    <= idx + 1'b1;
                        launch <= 1'b1;
                    end
                end
                S_FRAME: if (fin) begin
                    launch <= 1'b1;
                    if (idx[2:0] == FRAME_LAST) begin
                        st       <= S_POLL;
                        poll_cnt <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_POLL: if (fin) begin
                    launch <= 1'b1;
                    if (!rx_byte[7]) begin
                        rsp_short  <= {8'h00, rx_byte};
                        res_q      <= token_good(rx_byte) ? ERR_NONE : ERR_IO;
                        extra_left <= trailing_bytes(cmd_q.kind);
                        if (trailing_bytes(cmd_q.kind) != 3'd0) begin
                            st <= S_EXTRA;
                        end else begin
                            st   <= S_TAIL;
                            cs_n <= 1'b1;
                        end
                    end else if (poll_cnt == POLL_LAST) begin
                        res_q <= ERR_TIMEOUT;
                        st    <= S_TAIL;
                        cs_n  <= 1'b1;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                S_EXTRA: if (fin) begin
                    launch     <= 1'b1;
                    extra_left <= extra_left - 3'd1;
                    if (cmd_q.kind == 2'd1)
                        rsp_short[15:8] <= rx_byte;
                    else
                        rsp_word <= {rsp_word[23:0], rx_byte};
                    if (extra_left == 3'd1) begin
                        st   <= S_TAIL;
                        cs_n <= 1'b1;
                    end
                end
                S_TAIL: if (fin) begin
                    st    <= S_IDLE;
                    done  <= 1'b1;
                    err_q <= res_q;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R10: completion pulse lasts a single cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: error code moves only on completion or an accepted request
    p_err_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(st == S_IDLE && (start || wake_req))) |-> $stable(err_q));

    // R8: select stays inactive during the wake pattern
    p_wake_cs_r8: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAKE) |-> cs_n);

    // R9: select active through frame and response, inactive for the tail
    p_cs_frame_r9: assert property (@(posedge clk) disable iff (rst)
        (st == S_FRAME || st == S_POLL || st == S_EXTRA) |-> !cs_n);
    p_cs_tail_r9: assert property (@(posedge clk) disable iff (rst)
        (st == S_TAIL) |-> cs_n);

    // R3: poll count never passes its bound
    p_poll_bound_r3: assert property (@(posedge clk) disable iff (rst)
        poll_cnt <= POLL_LAST);

    // R11: latched command is frozen while a transaction runs
    p_cmd_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE && $past(st != S_IDLE)) |-> $stable(cmd_q));

endmodule

// File: rtl/spi_card_cmd.sv
module spi_card_cmd
    import spicmd_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int SLOW_DIV   = 144,
    parameter int FAST_DIV   = 48,
    parameter int TMO_LIMIT  = 1000,
    parameter int WAKE_BYTES = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wake_req,
    input  logic        start,
    input  logic [5:0]  opcode,
    input  logic [31:0] arg,
    input  logic [1:0]  rsp_kind,
    output logic        busy,
    output logic        done,
    output logic [1:0]  err,
    output logic [15:0] rsp_short,
    output logic [31:0] rsp_word,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n
);
    cmd_t             cmd_in;
    cmd_t             cmd_q;
    logic             go;
    logic             fin;
    logic             sh_active;
    logic [7:0]       tx_byte;
    logic [7:0]       rx_byte;
    logic [7:0]       frame_byte;
    logic [2:0]       frame_idx;
    logic [DIV_W-1:0] div;

    assign cmd_in = '{op: opcode, arg: arg, kind: rsp_kind};

    spicmd_frame_mux u_frame (
        .idx        (frame_idx),
        .op         (cmd_q.op),
        .arg        (cmd_q.arg),
        .frame_byte (frame_byte)
    );

    spicmd_sequencer #(
        .DIV_W      (DIV_W),
        .SLOW_DIV   (SLOW_DIV),
        .FAST_DIV   (FAST_DIV),
        .TMO_LIMIT  (TMO_LIMIT),
        .WAKE_BYTES (WAKE_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .wake_req   (wake_req),
        .start      (start),
        .cmd_in     (cmd_in),
        .fin        (fin),
        .rx_byte    (rx_byte),
        .frame_byte (frame_byte),
        .frame_idx  (frame_idx),
        .cmd_q      (cmd_q),
        .go         (go),
        .tx_byte    (tx_byte),
        .div        (div),
        .cs_n       (cs_n),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .rsp_short  (rsp_short),
        .rsp_word   (rsp_word)
    );

    spicmd_shifter #(
        .DIV_W (DIV_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .tx_byte (tx_byte),
        .div     (div),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .fin     (fin),
        .rx_byte (rx_byte),
        .active  (sh_active)
    );

    // R11: a byte is never launched over one still moving
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
        go |-> !sh_active);

endmodule

// File: tb/tb_spi_card_cmd.sv
module tb_spi_card_cmd;
    localparam int SLOW = 7;
    localparam int FAST = 3;
    localparam int TMO  = 6;
    localparam int WAKE = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wake_req = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  opcode = '0;
    logic [31:0] arg = '0;
    logic [1:0]  rsp_kind = '0;
    logic        busy, done, sclk, mosi, cs_n;
    logic [1:0]  err;
    logic [15:0] rsp_short;
    logic [31:0] rsp_word;
    logic        miso_r = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0] cap   [0:63];
    logic       cs_at [0:63];
    logic [7:0] rb    [0:15];
    int nrb = 0;
    int nr = 0;
    int nb = 0;
    int rt0 = 0;
    int rt1 = 0;

    spi_card_cmd #(
        .DIV_W(8), .SLOW_DIV(SLOW), .FAST_DIV(FAST),
        .TMO_LIMIT(TMO), .WAKE_BYTES(WAKE)
    ) dut (
        .clk(clk), .rst(rst), .wake_req(wake_req), .start(start),
        .opcode(opcode), .arg(arg), .rsp_kind(rsp_kind),
        .busy(busy), .done(done), .err(err),
        .rsp_short(rsp_short), .rsp_word(rsp_word),
        .sclk(sclk), .mosi(mosi), .miso(miso_r), .cs_n(cs_n)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    // card model: capture on rising clock, present data on falling clock
    always @(posedge sclk) begin
        if (nr < 512) begin
            if (nr % 8 == 0) cs_at[nr / 8] = cs_n;
            cap[nr / 8] = {cap[nr / 8][6:0], mosi};
        end
        if (nr == 0) rt0 = cyc;
        if (nr == 1) rt1 = cyc;
        nr++;
    end

    function automatic logic [7:0] card_byte(input int bi);
        if (bi >= 8 && (bi - 8) < nrb) return rb[bi - 8];
        return 8'hFF;
    endfunction

    always @(negedge sclk) begin
        nb++;
        miso_r = card_byte(nb / 8)[7 - (nb % 8)];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_frame(input logic [5:0] op, input logic [31:0] a, input int i);
        case (i)
            1: return {2'b01, op};
            2: return a[31:24];
            3: return a[23:16];
            4: return a[15:8];
            5: return a[7:0];
            6: return (op == 0) ? 8'h95 : (op == 8) ? 8'h87 : 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic int n_extra(input logic [1:0] k);
        return (k == 2'd1) ? 1 : (k == 2'd2) ? 4 : 0;
    endfunction

    task automatic model_clear();
        nr = 0; nb = 0; miso_r = 1'b1;
        for (int i = 0; i < 64; i++) begin cap[i] = 8'h00; cs_at[i] = 1'bx; end
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    // lead: number of 0xFF bytes before the token; lead >= TMO means timeout
    task automatic run_cmd(input logic [5:0] op, input logic [31:0] a, input logic [1:0] k,
                           input int lead, input logic [7:0] first, input logic [31:0] ex,
                           input bit interfere);
        int total, ne, nr_end;
        logic [1:0]  e_err;
        logic [15:0] e_short;
        logic [31:0] e_word;
        bit tmo;
        logic [1:0] err_seen;
        model_clear();
        tmo = (lead >= TMO);
        ne = n_extra(k);
        nrb = 0;
        for (int i = 0; i < lead && i < 16; i++) begin rb[nrb] = 8'hFF; nrb++; end
        if (!tmo) begin
            rb[nrb] = first; nrb++;
            for (int i = 0; i < ne; i++) begin rb[nrb] = ex[31 - 8*i -: 8]; nrb++; end
        end
        if (tmo) begin
            total = 8 + TMO + 1; e_err = 2'd1; e_short = 16'h0; e_word = 32'h0;
        end else begin
            total = 8 + lead + 1 + ne + 1;
            e_err = (first == 8'h00 || first == 8'h01) ? 2'd0 : 2'd2;
            e_short = (k == 2'd1) ? {ex[31:24], first} : {8'h00, first};
            e_word = (k == 2'd2) ? ex : 32'h0;
        end
        @(negedge clk);
        opcode = op; arg = a; rsp_kind = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (interfere) begin
            repeat (30) @(negedge clk);
            opcode = 6'h3F; arg = 32'hDEADBEEF; rsp_kind = 2'd2; start = 1'b1; wake_req = 1'b1;
            @(negedge clk);
            start = 1'b0; wake_req = 1'b0;
        end
        wait_done();
        // R1, R2: frame bytes
        for (int i = 0; i < 8; i++)
            check((i == 6) ? "R2 check byte" : "R1 frame byte", {24'h0, cap[i]}, {24'h0, exp_frame(op, a, i)});
        // R9: select window and trailing byte
        for (int i = 0; i < total; i++)
            check("R9 select per byte", {31'h0, cs_at[i]}, {31'h0, (i == total - 1)});
        check("R9 tail byte is idle", {24'h0, cap[total - 1]}, 32'hFF);
        check("R3 R5 byte count", nr, total * 8);
        check("R7 bit period", rt1 - rt0, (op == 0) ? SLOW + 1 : FAST + 1);
        check(tmo ? "R3 timeout code" : "R6 err code", {30'h0, err}, {30'h0, e_err});
        check("R4 rsp_short", {16'h0, rsp_short}, {16'h0, e_short});
        check("R5 rsp_word", rsp_word, e_word);
        err_seen = err;
        nr_end = nr;
        @(negedge clk);
        check("R10 done one cycle", {31'h0, done}, 32'h0);
        check("R7 sclk idle low", {31'h0, sclk}, 32'h0);
        repeat (10) @(negedge clk);
        check("R10 err held", {30'h0, err}, {30'h0, err_seen});
        if (interfere) begin
            check("R11 no second transaction", nr, nr_end);
            check("R11 idle after", {31'h0, busy}, 32'h0);
        end
    endtask

    task automatic run_wake();
        model_clear();
        nrb = 0;
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        wait_done();
        check("R8 wake bit count", nr, WAKE * 8);
        for (int i = 0; i < WAKE; i++) begin
            check("R8 wake byte", {24'h0, cap[i]}, 32'hFF);
            check("R8 wake select high", {31'h0, cs_at[i]}, 32'h1);
        end
        check("R8 wake bit period", rt1 - rt0, SLOW + 1);
        check("R8 wake err", {30'h0, err}, 32'h0);
        @(negedge clk);
        check("R10 wake done one cycle", {31'h0, done}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset busy", {31'h0, busy}, 32'h0);
        check("R9 reset cs_n", {31'h0, cs_n}, 32'h1);
        check("R7 reset sclk", {31'h0, sclk}, 32'h0);
        check("R1 reset mosi", {31'h0, mosi}, 32'h1);
        check("R10 reset done/err", {29'h0, done, err}, 32'h0);

        run_wake();
        // directed corners
        run_cmd(6'd0, 32'h0, 2'd0, 0, 8'h01, 32'h0, 1'b0);              // R2 R7 slow
        run_cmd(6'd8, 32'h000001AA, 2'd2, 1, 8'h01, 32'h000001AA, 1'b0); // R2 R5
        run_cmd(6'd13, 32'h0, 2'd1, 2, 8'h00, 32'hA5000000, 1'b0);       // R4
        run_cmd(6'd17, 32'h12345678, 2'd0, TMO, 8'h00, 32'h0, 1'b0);     // R3 timeout
        run_cmd(6'd17, 32'h9ABCDEF0, 2'd0, TMO - 1, 8'h00, 32'h0, 1'b0); // R3 last poll
        run_cmd(6'd58, 32'h0, 2'd2, 0, 8'h04, 32'hC0FF8000, 1'b0);       // R6 R5
        run_cmd(6'd24, 32'h00000200, 2'd3, 0, 8'h00, 32'h0, 1'b0);       // R5 kind 3
        run_cmd(6'd16, 32'h00000200, 2'd0, 0, 8'h01, 32'h0, 1'b1);       // R11
        // random traffic
        for (int n = 0; n < 14; n++) begin
            logic [5:0]  rop;
            logic [31:0] rarg, rex;
            logic [1:0]  rk;
            logic [7:0]  rf;
            int          rl;
            rop  = 6'($urandom_range(0, 63));
            rarg = $urandom;
            rex  = $urandom;
            rk   = 2'($urandom_range(0, 3));
            rl   = $urandom_range(0, 3);
            rf   = ($urandom_range(0, 3) == 0) ? {1'b0, 7'($urandom)} : 8'($urandom_range(0, 1));
            run_cmd(rop, rarg, rk, rl, rf, rex, 1'b0);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule